// File: doc/BRIEF.md
# Channel Protection and Fault Recovery Sequencer

This block watches eleven switched outputs and the supply rail for faults and decides, cycle by cycle, whether each output may be driven. When a channel reports an overcurrent, the block turns that channel off at once and records a sticky per-channel status bit. A shared fault flag is raised at the same time. A per-channel enable decides what happens next. With the enable clear, the channel waits for software to acknowledge the fault. With the enable set, the channel is turned back on by itself after a timed delay.

The delay comes from a single rate input, which picks a long or a short wait. Two dual-mode channels instead use a fixed medium delay while they run in bulb mode. Over-voltage and under-voltage detects drive all channels off together. Depending on a hold input, outputs either come back as soon as the supply fault goes away, or stay off until software clears the recorded supply status. Every status bit is cleared only by a write-one-to-clear strobe, and a clear has no effect while its fault input is still asserted.

Top module: `prot_recovery_ctrl`

## Requirements
- R1: When `oc_det[i]` is sampled high at a clock edge, `oc_sts[i]` is 1 and `permit[i]` is 0 after that edge. Other channels' `permit` bits are unaffected.
- R2: `glob_flt` is 1 exactly while at least one of `oc_sts`, `ov_sts`, `uv_sts` is set.
- R3: With `rec_en[i]`=0, a tripped channel stays off until a `clr_oc[i]` pulse is accepted. After the accepting edge, `oc_sts[i]`=0 and `permit[i]`=1.
- R4: With `rec_en[i]`=1, `permit[i]` returns to 1 exactly D edges after the last edge that sampled `oc_det[i]` high, and `oc_sts[i]` stays set.
- R5: D is SLOW_DLY (default 4096) when `fast_rate`=0 and FAST_DLY (default 256) when `fast_rate`=1. Both are taken at the edge that samples the fault.
- R6: For channels whose bit is set in BULB_MASK (default channels 6 and 7), `bulb_mode[i]`=1 selects BULB_DLY (default 1024) whatever `fast_rate` is. On all other channels `bulb_mode` has no effect.
- R7: A new overcurrent during a countdown restarts the delay from its full value.
- R8: A clear strobe (`clr_oc[i]`, `clr_ov`, `clr_uv`) at an edge where the matching detect is high is ignored, and the status bit stays set.
- R9: `ov_sts`/`uv_sts` are set after an edge that samples `ov_det`/`uv_det` high. With `ovuv_hold`=0, all `permit` bits are 0 after every edge that samples a supply detect high, and they return one edge after the detect is sampled low.
- R10: With `ovuv_hold`=1, all `permit` bits stay 0 while `ov_sts` or `uv_sts` is set, until the status is cleared.
- R11: After reset, all status bits and `glob_flt` are 0 and all `permit` bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_det | input | NCH | Per-channel overcurrent detect |
| rec_en | input | NCH | Per-channel automatic recovery enable |
| bulb_mode | input | NCH | Bulb-mode flag (honoured on BULB_MASK channels) |
| fast_rate | input | 1 | 1 selects the short recovery delay |
| ovuv_hold | input | 1 | 1 holds outputs off until supply status is cleared |
| ov_det | input | 1 | Over-voltage detect |
| uv_det | input | 1 | Under-voltage detect |
| clr_oc | input | NCH | Write-one-to-clear strobe for overcurrent status |
| clr_ov | input | 1 | Write-one-to-clear strobe for over-voltage status |
| clr_uv | input | 1 | Write-one-to-clear strobe for under-voltage status |
| permit | output | NCH | Per-channel output permit |
| oc_sts | output | NCH | Sticky overcurrent status |
| ov_sts | output | 1 | Sticky over-voltage status |
| uv_sts | output | 1 | Sticky under-voltage status |
| glob_flt | output | 1 | Shared fault flag |

## Verification
Every status bit and the permit response to a fault or a clear appear one edge after the stimulus is sampled. The automatic re-enable appears exactly D edges after the last faulty sample. Stimulus is applied on falling edges and outputs are read at the following falling edges. This puts each result at a known count of rising edges after its stimulus. The recovery sweep over every channel, rate, bulb flag and enable setting counts falling edges until `permit` rises and compares the count with the delay computed from the configuration. The bench uses small delay parameters so that every combination fits in a short run.

// File: rtl/prot_pkg.sv
package prot_pkg;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/prot_chan.sv
module prot_chan #(
   parameter int CW       = 12,
   parameter int SLOW_DLY = 4096,
   parameter int FAST_DLY = 256,
   parameter int BULB_DLY = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oc_det,
   input  logic rec_en,
   input  logic fast_rate,
   input  logic bulb_en,
   input  logic clr,
   output logic off_o,
   output logic sts_o
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] load_val;
   logic          off_q;
   logic          sts_q;
   logic          clr_ok;

   always_comb begin
      if (bulb_en)        load_val = CW'(BULB_DLY - 1);
      else if (fast_rate) load_val = CW'(FAST_DLY - 1);
      else                load_val = CW'(SLOW_DLY - 1);
   end

   assign clr_ok = clr & ~oc_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         off_q <= 1'b0;
         sts_q <= 1'b0;
      end else if (oc_det) begin
         off_q <= 1'b1;
         sts_q <= 1'b1;
         cnt_q <= load_val;
      end else if (clr_ok) begin
         off_q <= 1'b0;
         sts_q <= 1'b0;
      end else if (off_q && rec_en) begin
         if (cnt_q == '0) off_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign off_o = off_q;
   assign sts_o = sts_q;

   // R1
   trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oc_det |=> (off_q && sts_q));

   // R3
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off_q && !rec_en && !clr && !oc_det) |=> off_q);

   // R4
   expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off_q && rec_en && !oc_det && !clr && cnt_q == '0) |=> (!off_q && sts_q));

   // R7
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oc_det |=> (cnt_q == $past(load_val)));

   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q && oc_det) |=> sts_q);

endmodule

// File: rtl/prot_supply.sv
module prot_supply #(
   parameter int NL = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NL-1:0] det,
   input  logic [NL-1:0] clr,
   input  logic          hold,
   output logic [NL-1:0] sts,
   output logic          blk
);

   logic [NL-1:0] live_q;
   logic [NL-1:0] sts_q;

   for (genvar l = 0; l < NL; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            live_q[l] <= 1'b0;
            sts_q[l]  <= 1'b0;
         end else begin
            live_q[l] <= det[l];
            if (det[l])      sts_q[l] <= 1'b1;
            else if (clr[l]) sts_q[l] <= 1'b0;
         end
      end

      // R8
      lane_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_q[l] && det[l]) |=> sts_q[l]);
   end

   assign sts = sts_q;
   assign blk = (|live_q) | (hold & (|sts_q));

   // R9
   live_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (det != '0) |=> (blk && sts_q != '0));

   // R10
   held_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && sts_q != '0 && clr == '0) |=> (blk || !hold));

endmodule

// File: rtl/prot_recovery_ctrl.sv
module prot_recovery_ctrl #(
   parameter int              NCH       = 11,
   parameter int              SLOW_DLY  = 4096,
   parameter int              FAST_DLY  = 256,
   parameter int              BULB_DLY  = 1024,
   parameter logic [NCH-1:0]  BULB_MASK = NCH'(11'b000_1100_0000)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] oc_det,
   input  logic [NCH-1:0] rec_en,
   input  logic [NCH-1:0] bulb_mode,
   input  logic           fast_rate,
   input  logic           ovuv_hold,
   input  logic           ov_det,
   input  logic           uv_det,
   input  logic [NCH-1:0] clr_oc,
   input  logic           clr_ov,
   input  logic           clr_uv,
   output logic [NCH-1:0] permit,
   output logic [NCH-1:0] oc_sts,
   output logic           ov_sts,
   output logic           uv_sts,
   output logic           glob_flt
);

   import prot_pkg::*;

   localparam int MAXD = max3(SLOW_DLY, FAST_DLY, BULB_DLY);
   localparam int CW   = $clog2(MAXD);

   if (NCH < 1 || SLOW_DLY < 2 || FAST_DLY < 2 || BULB_DLY < 2) begin : g_bad_cfg
      $fatal(1, "prot_recovery_ctrl: NCH must be >= 1 and every delay >= 2");
   end

   logic [NCH-1:0] off;
   logic [NCH-1:0] bulb_en;
   logic [1:0]     sup_sts;
   logic           sup_blk;

   assign bulb_en = bulb_mode & BULB_MASK;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      prot_chan #(
         .CW       (CW),
         .SLOW_DLY (SLOW_DLY),
         .FAST_DLY (FAST_DLY),
         .BULB_DLY (BULB_DLY)
      ) i_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .oc_det    (oc_det[g]),
         .rec_en    (rec_en[g]),
         .fast_rate (fast_rate),
         .bulb_en   (bulb_en[g]),
         .clr       (clr_oc[g]),
         .off_o     (off[g]),
         .sts_o     (oc_sts[g])
      );
   end

   prot_supply #(.NL(2)) i_supply (
      .clk   (clk),
      .rst_n (rst_n),
      .det   ({uv_det, ov_det}),
      .clr   ({clr_uv, clr_ov}),
      .hold  (ovuv_hold),
      .sts   (sup_sts),
      .blk   (sup_blk)
   );

   assign ov_sts   = sup_sts[0];
   assign uv_sts   = sup_sts[1];
   assign permit   = ~off & {NCH{~sup_blk}};
   assign glob_flt = (|oc_sts) | ov_sts | uv_sts;

   // R2
   glob_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_det != '0) |=> glob_flt);

   // R1
   trip_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_det != '0) |=> ((permit & $past(oc_det)) == '0));

   // R10
   held_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovuv_hold && (ov_sts || uv_sts) && !clr_ov && !clr_uv) |=> (permit == '0 || !ovuv_hold));

endmodule

// File: tb/test_prot_recovery_ctrl.sv
`timescale 1ns/1ps
module test_prot_recovery_ctrl;

   localparam int NCH  = 11;
   localparam int SLOW = 40;
   localparam int FAST = 10;
   localparam int BULB = 20;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] oc_det = '0, rec_en = '0, bulb_mode = '0, clr_oc = '0;
   logic           fast_rate = 1'b0, ovuv_hold = 1'b0;
   logic           ov_det = 1'b0, uv_det = 1'b0, clr_ov = 1'b0, clr_uv = 1'b0;
   logic [NCH-1:0] permit, oc_sts;
   logic           ov_sts, uv_sts, glob_flt;

   int total = 0;
   int bad   = 0;
   localparam logic [NCH-1:0] ALL = '1;

   always #4 clk = ~clk;

   prot_recovery_ctrl #(
      .NCH(NCH), .SLOW_DLY(SLOW), .FAST_DLY(FAST), .BULB_DLY(BULB)
   ) i_prot_recovery_ctrl (
      .clk(clk), .rst_n(rst_n), .oc_det(oc_det), .rec_en(rec_en),
      .bulb_mode(bulb_mode), .fast_rate(fast_rate), .ovuv_hold(ovuv_hold),
      .ov_det(ov_det), .uv_det(uv_det), .clr_oc(clr_oc), .clr_ov(clr_ov),
      .clr_uv(clr_uv), .permit(permit), .oc_sts(oc_sts), .ov_sts(ov_sts),
      .uv_sts(uv_sts), .glob_flt(glob_flt)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_oc(input int ch);
      @(negedge clk) oc_det[ch] = 1'b1;
      @(negedge clk) oc_det[ch] = 1'b0;
   endtask

   task automatic clear_oc(input int ch);
      clr_oc[ch] = 1'b1;
      @(negedge clk) clr_oc[ch] = 1'b0;
   endtask

   task automatic sweep(input int ch, input bit f, input bit b, input bit r);
      int n;
      int d;
      logic [NCH-1:0] others;
      fast_rate = f; bulb_mode = '0; bulb_mode[ch] = b; rec_en = '0; rec_en[ch] = r;
      d = (b && (ch == 6 || ch == 7)) ? BULB : (f ? FAST : SLOW);
      others = ALL; others[ch] = 1'b0;
      pulse_oc(ch);
      chk(!permit[ch] && oc_sts[ch], "R1 trip", {permit[ch], oc_sts[ch]}, 1);
      chk((permit & others) == others, "R1 other channels", permit, others);
      chk(glob_flt, "R2 flag set", glob_flt, 1);
      if (r) begin
         n = 0;
         while (!permit[ch] && n < 200) begin
            @(negedge clk) n++;
         end
         chk(n == d, "R4 R5 R6 recovery delay", n, d);
         chk(oc_sts[ch], "R4 status kept", oc_sts[ch], 1);
      end else begin
         repeat (SLOW + 3) @(negedge clk);
         chk(!permit[ch], "R3 stays off", permit[ch], 0);
      end
      clear_oc(ch);
      chk(permit[ch] && !oc_sts[ch], "R3 clear", {permit[ch], oc_sts[ch]}, 2);
      chk(!glob_flt, "R2 flag clear", glob_flt, 0);
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", total, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(permit == ALL, "R11 permit", permit, ALL);
      chk(oc_sts == '0 && !ov_sts && !uv_sts && !glob_flt, "R11 status",
          {oc_sts, ov_sts, uv_sts, glob_flt}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(permit == ALL, "R11 after release", permit, ALL);

      for (int ch = 0; ch < NCH; ch++)
         for (int f = 0; f < 2; f++)
            for (int b = 0; b < 2; b++)
               for (int r = 0; r < 2; r++)
                  sweep(ch, f[0], b[0], r[0]);

      // R7 restart on new event
      fast_rate = 1'b1; bulb_mode = '0; rec_en = '0; rec_en[2] = 1'b1;
      pulse_oc(2);
      repeat (5) @(negedge clk);
      pulse_oc(2);
      n = 0;
      while (!permit[2] && n < 200) begin
         @(negedge clk) n++;
      end
      chk(n == FAST, "R7 restart", n, FAST);
      clear_oc(2);

      // R8 clear ignored while overcurrent active
      rec_en = '0;
      @(negedge clk) oc_det[4] = 1'b1;
      @(negedge clk) clr_oc[4] = 1'b1;
      @(negedge clk) begin clr_oc[4] = 1'b0; oc_det[4] = 1'b0; end
      @(negedge clk);
      chk(oc_sts[4] && !permit[4], "R8 oc clear ignored", oc_sts[4], 1);
      clear_oc(4);
      chk(!oc_sts[4] && permit[4], "R8 oc clear after release", oc_sts[4], 0);

      // R9 automatic supply recovery
      ovuv_hold = 1'b0;
      @(negedge clk) ov_det = 1'b1;
      @(negedge clk);
      chk(permit == '0 && ov_sts && glob_flt, "R9 ov blocks", permit, 0);
      ov_det = 1'b0;
      @(negedge clk);
      chk(permit == ALL && ov_sts, "R9 ov auto resume", permit, ALL);
      clr_ov = 1'b1;
      @(negedge clk) clr_ov = 1'b0;
      chk(!ov_sts && !glob_flt, "R9 ov cleared", ov_sts, 0);

      // R10 held supply fault, with R8 on a supply lane
      ovuv_hold = 1'b1;
      @(negedge clk) uv_det = 1'b1;
      @(negedge clk) clr_uv = 1'b1;
      @(negedge clk) begin clr_uv = 1'b0; uv_det = 1'b0; end
      chk(uv_sts, "R8 uv clear ignored", uv_sts, 1);
      repeat (10) @(negedge clk);
      chk(permit == '0 && uv_sts, "R10 held off", permit, 0);
      clr_uv = 1'b1;
      @(negedge clk) clr_uv = 1'b0;
      chk(permit == ALL && !uv_sts, "R10 resume after clear", permit, ALL);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule